// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns a byte stream, delivered in one or more buffer segments, into complete outgoing Ethernet frames. Every byte presented on the input carries the flags of its segment. A segment ends on the byte marked `in_last`. The frame ends on the first segment whose last byte also has `in_eop` set. Header and payload bytes go out unchanged and in order. If padding is enabled and the frame is still short, zero bytes are added to reach the minimum size. If the final byte requests a checksum, a 4-byte frame check sequence follows. The output is a byte stream with start-of-frame and end-of-frame markers and an error marker.

The control is one state machine with five states:

- IDLE waits for the first byte of a frame. Accepting it moves to DATA, or straight to PAD, FCS or back to IDLE for a one-byte frame.
- DATA passes bytes through until the frame end. It then goes to PAD when the frame is short and padding is on, else to FCS when a checksum is requested, else to IDLE.
- PAD emits zeros with the input stalled. When the body reaches its minimum it goes to FCS, or to IDLE if no checksum was requested.
- FCS emits four checksum bytes, then returns to IDLE.
- DROP is entered when the body reaches its maximum before the frame ends. It discards input up to the frame end, then returns to IDLE.

Outputs are registered, so every emitted byte appears one cycle after the cycle that produced it.

Top module: `tx_frame_fmt`

## Requirements
- R1: After reset `out_valid`, `out_sof`, `out_eof` and `out_err` are 0 and `in_ready` is 1.
- R2: A byte accepted on a clock edge (`in_valid` and `in_ready` high) appears on `out_data` with `out_valid` high after that edge, unchanged and in input order. The first byte of each frame has `out_sof` = 1, and no other byte does.
- R3: A frame ends only at a byte with both `in_last` = 1 and `in_eop` = 1. Segment boundaries without `in_eop` join the segments into one frame, and `in_eop` on a byte without `in_last` has no effect.
- R4: When `pad_en` = 1 at the frame's final byte and the frame has fewer than 60 bytes before the checksum, zero bytes are emitted until the body is 60 bytes. A body of 60 bytes or more gets no padding.
- R5: When `pad_en` = 0, no padding is added, whatever the frame length.
- R6: When `in_ifcs` = 1 on the final byte, 4 checksum bytes follow the body, including any padding. The checksum is CRC-32: reflected polynomial 0xEDB88320, register preset to all ones, result inverted, least significant byte sent first.
- R7: `in_ifcs` on any byte other than the final one is ignored. With `in_ifcs` = 0 on the final byte, no checksum is added.
- R8: While padding or checksum bytes are emitted, `in_ready` is 0.
- R9: A frame whose body would exceed 1532 bytes (1536 with checksum) is cut at byte 1532. That byte carries `out_eof` = 1 and `out_err` = 1, no padding or checksum follows, and the remaining input is accepted and discarded up to the frame end. A body of exactly 1532 bytes is sent normally, and the next frame is unaffected.
- R10: `out_eof` is 1 on exactly one byte per frame, its last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte is the last of its segment |
| in_eop | input | 1 | Segment ends the frame (used with `in_last`) |
| in_ifcs | input | 1 | Append checksum (used on the frame's final byte) |
| pad_en | input | 1 | Pad short frames to minimum size |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame was truncated (on its last byte) |

## Verification
A state machine stuck in the wrong state shows at the ports in one of two ways. It holds `in_ready` low with no output, or it emits bytes while input is still accepted. Either shows within a cycle of the frame end. A wrong length count shows as a frame one or more bytes too long or too short, visible at its `out_eof`. A wrong checksum register shows only in the four trailing bytes, so every checksum frame is compared byte for byte against an independent CRC. The truncation path needs a body longer than 1532 bytes to be reached, so it is driven explicitly. A normal frame follows it to show that DROP returns to IDLE.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_DROP
    } fmt_state_t;

    localparam int          FCS_BYTES     = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

    // One byte of reflected CRC-32, bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_fmt_crc.sv
module tx_fmt_crc
    import tx_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic        first,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else if (upd) begin
            crc_q <= crc32_step(first ? CRC_PRESET : crc_q, din);
        end
    end

endmodule

// File: rtl/tx_fmt_len.sv
module tx_fmt_len #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             first,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= first ? CNT_W'(1) : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tx_frame_fmt.sv
module tx_frame_fmt
    import tx_fmt_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_eop,
    input  logic       in_ifcs,
    input  logic       pad_en,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err
);

    localparam int               CNT_W    = $clog2(MAX_FRAME + 1);
    localparam logic [CNT_W-1:0] MIN_BODY = CNT_W'(MIN_FRAME - FCS_BYTES);
    localparam logic [CNT_W-1:0] MAX_BODY = CNT_W'(MAX_FRAME - FCS_BYTES);

    fmt_state_t       state, nxt;
    logic             ifcs_q;
    logic [1:0]       fcs_idx;
    logic [CNT_W-1:0] cnt, cnt_cur, cnt_nxt;
    logic [31:0]      crc_q, fcs_word;
    logic             acc, frame_end, first;
    logic             emit, body_upd, sof_n, eof_n, err_n;
    logic [7:0]       byte_n;

    assign in_ready  = (state == ST_IDLE) || (state == ST_DATA) || (state == ST_DROP);
    assign acc       = in_valid && in_ready;
    assign frame_end = in_last && in_eop;
    assign first     = (state == ST_IDLE);
    assign cnt_cur   = first ? '0 : cnt;
    assign cnt_nxt   = cnt_cur + 1'b1;
    assign fcs_word  = ~crc_q;

    tx_fmt_crc crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (body_upd),
        .first (first),
        .din   (byte_n),
        .crc_q (crc_q)
    );

    tx_fmt_len #(.CNT_W(CNT_W)) len_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (body_upd),
        .first (first),
        .cnt   (cnt)
    );

    // Next state and per-cycle emission decision
    always_comb begin
        nxt      = state;
        emit     = 1'b0;
        body_upd = 1'b0;
        sof_n    = 1'b0;
        eof_n    = 1'b0;
        err_n    = 1'b0;
        byte_n   = in_data;
        unique case (state)
            ST_IDLE, ST_DATA: begin
                if (acc) begin
                    emit     = 1'b1;
                    body_upd = 1'b1;
                    sof_n    = first;
                    if (frame_end) begin
                        if (pad_en && (cnt_nxt < MIN_BODY)) begin
                            nxt = ST_PAD;
                        end else if (in_ifcs) begin
                            nxt = ST_FCS;
                        end else begin
                            eof_n = 1'b1;
                            nxt   = ST_IDLE;
                        end
                    end else if (cnt_nxt == MAX_BODY) begin
                        eof_n = 1'b1;
                        err_n = 1'b1;
                        nxt   = ST_DROP;
                    end else begin
                        nxt = ST_DATA;
                    end
                end
            end
            ST_PAD: begin
                emit     = 1'b1;
                body_upd = 1'b1;
                byte_n   = 8'h00;
                if (cnt_nxt == MIN_BODY) begin
                    if (ifcs_q) begin
                        nxt = ST_FCS;
                    end else begin
                        eof_n = 1'b1;
                        nxt   = ST_IDLE;
                    end
                end
            end
            ST_FCS: begin
                emit   = 1'b1;
                byte_n = fcs_word[8*fcs_idx +: 8];
                if (fcs_idx == 2'd3) begin
                    eof_n = 1'b1;
                    nxt   = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (acc && frame_end) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ifcs_q  <= 1'b0;
            fcs_idx <= 2'd0;
        end else begin
            state   <= nxt;
            fcs_idx <= (state == ST_FCS) ? fcs_idx + 2'd1 : 2'd0;
            if (acc && frame_end && (state == ST_IDLE || state == ST_DATA)) begin
                ifcs_q <= in_ifcs;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_data  <= byte_n;
            out_sof   <= sof_n;
            out_eof   <= eof_n;
            out_err   <= err_n;
        end
    end

endmodule

// File: rtl/tx_frame_fmt_chk.sv
module tx_frame_fmt_chk
    import tx_fmt_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int MAX_BODY = 1532
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             out_err,
    input fmt_state_t       state,
    input logic [CNT_W-1:0] cnt
);

    // R2
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R10
    eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R9
    err_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof);

    // R2
    accept_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && state != ST_DROP) |=> out_valid);

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |=> (out_valid && out_data == 8'h00 && !out_sof));

    // R6
    fcs_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FCS) |=> (out_valid && !out_sof && !out_err));

    // R9
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= MAX_BODY);

endmodule

bind tx_frame_fmt tx_frame_fmt_chk #(
    .CNT_W    (CNT_W),
    .MAX_BODY (MAX_FRAME - 4)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_err   (out_err),
    .state     (state),
    .cnt       (cnt)
);

// File: tb/tx_frame_fmt_tb_top.sv
`timescale 1ns/1ps
module tx_frame_fmt_tb_top;

    localparam int BODY_MAX = 1532;
    localparam int BODY_MIN = 60;
    localparam int NVEC     = 9;
    // {length, segment size, pad, ifcs}
    localparam logic [33:0] VEC [NVEC] = '{
        {16'd20,   16'd20,  1'b1, 1'b1},
        {16'd20,   16'd20,  1'b0, 1'b1},
        {16'd60,   16'd60,  1'b1, 1'b1},
        {16'd59,   16'd25,  1'b1, 1'b1},
        {16'd100,  16'd7,   1'b0, 1'b1},
        {16'd64,   16'd16,  1'b1, 1'b0},
        {16'd1,    16'd1,   1'b1, 1'b0},
        {16'd1,    16'd1,   1'b0, 1'b0},
        {16'd1532, 16'd500, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_eop = 1'b0, in_ifcs = 1'b0, pad_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_sof, out_eof, out_err;
    logic [7:0] out_data;

    int tests = 0;
    int fails = 0;
    logic [10:0] got[$];
    logic [10:0] exp[$];

    always #2 clk = ~clk;

    tx_frame_fmt dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_eop(in_eop), .in_ifcs(in_ifcs), .pad_en(pad_en),
        .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) got.push_back({out_err, out_eof, out_sof, out_data});
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int len);
        return 8'((i * 13 + len) & 255);
    endfunction

    task automatic send_frame(input int len, input int seg, input bit pad,
                              input bit ifcs, input bit ifcs_mid);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = pat(i, len);
            in_last  = ((i + 1) % seg == 0) || (i == len - 1);
            in_eop   = (i >= ((len - 1) / seg) * seg);
            in_ifcs  = (i == len - 1) ? ifcs : ifcs_mid;
            pad_en   = pad;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_eop = 1'b0; in_ifcs = 1'b0;
    endtask

    task automatic build_exp(input int len, input bit pad, input bit ifcs);
        int n;
        logic [31:0] c;
        logic [7:0] b;
        exp.delete();
        n = (len > BODY_MAX) ? BODY_MAX : len;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) exp.push_back({3'b000, pat(i, len)});
        if (len > BODY_MAX) begin
            exp[n-1][10:9] = 2'b11;
        end else begin
            if (pad) while (exp.size() < BODY_MIN) exp.push_back(11'h000);
            if (ifcs) begin
                for (int i = 0; i < exp.size(); i++) begin
                    b = exp[i][7:0];
                    for (int k = 0; k < 8; k++) begin
                        c = ((c[0] ^ b[k]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
                    end
                end
                c = ~c;
                for (int k = 0; k < 4; k++) exp.push_back({3'b000, c[8*k +: 8]});
            end
            exp[exp.size()-1][9] = 1'b1;
        end
        exp[0][8] = 1'b1;
    endtask

    task automatic compare(input string req);
        int bad = -1;
        chk(got.size() == exp.size(), req, "frame length", got.size(), exp.size());
        if (got.size() == exp.size()) begin
            for (int i = 0; i < exp.size(); i++) if (bad < 0 && got[i] !== exp[i]) bad = i;
        end
        chk(bad < 0, req, "byte and flags", (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : exp[bad]);
    endtask

    task automatic drain();
        repeat (80) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && !out_sof && !out_eof && !out_err, "R1", "outputs idle",
            {out_valid, out_sof, out_eof, out_err}, 0);
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            int len  = int'(VEC[v][33:18]);
            int seg  = int'(VEC[v][17:2]);
            got.delete();
            build_exp(len, VEC[v][1], VEC[v][0]);
            send_frame(len, seg, VEC[v][1], VEC[v][0], 1'b0);
            drain();
            compare($sformatf("R2/R3/R4/R5/R6/R10 vec%0d", v));
        end

        // R2: one-cycle latency, single byte frame
        got.delete();
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1; in_eop = 1'b1;
        in_ifcs = 1'b0; pad_en = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_eop = 1'b0;
        chk(out_valid && out_sof && out_eof && out_data == 8'hA5, "R2", "latency",
            {out_valid, out_sof, out_eof, out_data}, {3'b111, 8'hA5});
        @(negedge clk);
        chk(!out_valid, "R2", "single output", out_valid, 0);

        // R8: input stalled during pad and checksum
        got.delete();
        build_exp(5, 1'b1, 1'b1);
        send_frame(5, 5, 1'b1, 1'b1, 1'b0);
        chk(in_ready == 1'b0, "R8", "in_ready during pad", in_ready, 0);
        drain();
        chk(in_ready == 1'b1, "R8", "in_ready after frame", in_ready, 1);
        compare("R8/R4/R6 short padded");

        // R7: ifcs on non-final bytes ignored
        got.delete();
        build_exp(30, 1'b0, 1'b0);
        send_frame(30, 10, 1'b0, 1'b0, 1'b1);
        drain();
        compare("R7 mid ifcs");

        // R3: eop without last mid-segment, final eop on later segment
        got.delete();
        build_exp(12, 1'b0, 1'b1);
        send_frame(12, 4, 1'b0, 1'b1, 1'b0);
        drain();
        compare("R3 multi segment");

        // R9: truncation, then a normal frame
        got.delete();
        build_exp(1540, 1'b0, 1'b1);
        send_frame(1540, 600, 1'b0, 1'b1, 1'b0);
        drain();
        compare("R9 truncated");
        got.delete();
        build_exp(20, 1'b1, 1'b1);
        send_frame(20, 20, 1'b1, 1'b1, 1'b0);
        drain();
        compare("R9 after truncation");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule